// File: doc/BRIEF.md
# Prescaled BCD Real-Time Calendar

This block keeps wall-clock time and calendar date from a slow clock of about 32 kHz. Two down-counting prescalers turn that clock into a one-second tick. The first has a 7-bit reload value and the second a 15-bit reload value. The block divides by (async_div + 1) × (sync_div + 1). With a 32768 Hz clock, reload values of 127 and 255 give 1 Hz. With a 32000 Hz clock, 127 and 249 give 1 Hz. The current count of the second prescaler can be read back as a sub-second value. It counts down, so the elapsed part of the current second is (sync_div − value) / (sync_div + 1).

Time is kept as BCD hours, minutes and seconds in 24-hour form. The date is kept as a BCD year from 00 to 99, a month, a day of the month, and a weekday numbered 1 to 7 with Monday as 1. Software enters init mode to stop counting and load new time and date words. It then leaves init mode, and counting restarts from the loaded values.

Reads go through shadow copies, so a multi-word read stays coherent. A read strobe on the time word freezes the date shadow until the date word is read. A read strobe on the sub-second word freezes both the time and date shadows in the same way. A sync flag tells software that the shadows hold a fresh copy of the live counters, and software can clear it.

Top module: `bcd_calendar`

## Requirements
- R1: Outside init mode the time advances by exactly one second every (async_div + 1) × (sync_div + 1) clock cycles. The first advance comes that many cycles after init mode is left. The shadow, and so `rd_data`, shows the new value one cycle after the live counter changes.
- R2: The sub-second value is placed in bits [14:0] of the word selected by `rd_sel` = 0. It counts down from `sync_div` to 0, moving one step every async_div + 1 cycles, and then reloads `sync_div`.
- R3: The time word uses this layout: second units in [3:0], second tens in [6:4], minute units in [11:8], minute tens in [14:12], hour units in [19:16], hour tens in [21:20], and a PM bit in [22] that is always 0. All other bits are 0. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the date.
- R4: The date word uses this layout: day units in [3:0], day tens in [5:4], month units in [11:8], month tens in [12], year units in [19:16], year tens in [23:20], and weekday in [26:24]. On a day carry, the day wraps to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is divisible by 4 and 28 days otherwise. All other months have 31 days. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R5: The weekday steps by one on every day carry, and 7 wraps to 1.
- R6: While `init_mode` is high, both prescalers are held at their reload values and the calendar does not count. A write is accepted only in init mode: `wr_sel` = 0 loads the time word and `wr_sel` = 1 loads the date word. A write outside init mode changes nothing.
- R7: A `rd_en` strobe with `rd_sel` = 1 (time) freezes the date shadow. A strobe with `rd_sel` = 0 (sub-second) freezes the time, sub-second and date shadows. The frozen shadows hold until a strobe with `rd_sel` = 2 (date) is seen. With `rd_en` low, `rd_data` shows the selected shadow without locking anything.
- R8: `sync_flag` rises in the cycle after the date shadow takes a fresh copy. `sync_clr` clears the flag and wins over a set in the same cycle. While the date shadow is frozen, the flag stays clear once it has been cleared.
- R9: After reset the time reads 00:00:00 and the date reads year 00, month 01, day 01, weekday 1. `sync_flag` is 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Calendar clock, about 32 kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_mode | input | 1 | Hold counting and allow loading |
| async_div | input | 7 | Reload value of the first prescaler |
| sync_div | input | 15 | Reload value of the second prescaler |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 time, 1 date |
| wr_data | input | 32 | Word to load |
| rd_en | input | 1 | Read strobe; drives the shadow locking |
| rd_sel | input | 2 | Read select: 0 sub-second, 1 time, 2 date, 3 zero |
| rd_data | output | 32 | Selected shadow word |
| sync_clr | input | 1 | Clear the sync flag |
| sync_flag | output | 1 | Shadows hold a fresh copy |

## Verification
The prescaler is tried with two divider pairs. Timing is sampled on the exact cycles around the first tick, which separates an off-by-one reload from a correct one. The sub-second value is sampled every cycle over two seconds. Directed loads exercise these wraps:
- 30-day and 31-day month ends
- February 28 and February 29 in leap and non-leap years
- December 31 of year 99
- weekday 7

These separate each carry path. Random valid loads are biased toward the ends of the minute, hour and month and are compared with a bench calendar model. A locked read that spans a day change separates coherent shadowing from free copying. Writes and sync-flag clears issued during that window show that they are ignored or take priority.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int WORD_W = 32;

    typedef struct packed {
        logic [1:0] h_t;
        logic [3:0] h_u;
        logic [2:0] m_t;
        logic [3:0] m_u;
        logic [2:0] s_t;
        logic [3:0] s_u;
    } clock_t;

    typedef struct packed {
        logic [3:0] y_t;
        logic [3:0] y_u;
        logic       mo_t;
        logic [3:0] mo_u;
        logic [1:0] d_t;
        logic [3:0] d_u;
        logic [2:0] wd;
    } cal_date_t;

    typedef enum logic [1:0] {
        SEL_SUB  = 2'd0,
        SEL_TIME = 2'd1,
        SEL_DATE = 2'd2,
        SEL_NONE = 2'd3
    } rd_sel_e;

    localparam clock_t    CLOCK_RST = '0;
    localparam cal_date_t DATE_RST  = '{y_t: 4'd0, y_u: 4'd0, mo_t: 1'b0, mo_u: 4'd1,
                                        d_t: 2'd0, d_u: 4'd1, wd: 3'd1};

    function automatic logic [WORD_W-1:0] pack_clock(clock_t c);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[3:0]   = c.s_u;
        w[6:4]   = c.s_t;
        w[11:8]  = c.m_u;
        w[14:12] = c.m_t;
        w[19:16] = c.h_u;
        w[21:20] = c.h_t;
        return w;
    endfunction

    function automatic clock_t unpack_clock(logic [WORD_W-1:0] w);
        clock_t c;
        c.s_u = w[3:0];
        c.s_t = w[6:4];
        c.m_u = w[11:8];
        c.m_t = w[14:12];
        c.h_u = w[19:16];
        c.h_t = w[21:20];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_date(cal_date_t d);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[3:0]   = d.d_u;
        w[5:4]   = d.d_t;
        w[11:8]  = d.mo_u;
        w[12]    = d.mo_t;
        w[19:16] = d.y_u;
        w[23:20] = d.y_t;
        w[26:24] = d.wd;
        return w;
    endfunction

    function automatic cal_date_t unpack_date(logic [WORD_W-1:0] w);
        cal_date_t d;
        d.d_u  = w[3:0];
        d.d_t  = w[5:4];
        d.mo_u = w[11:8];
        d.mo_t = w[12];
        d.y_u  = w[19:16];
        d.y_t  = w[23:20];
        d.wd   = w[26:24];
        return d;
    endfunction

    // Year divisible by four, decided on the BCD digits directly
    function automatic logic is_leap(logic [3:0] y_t, logic [3:0] y_u);
        if (y_t[0]) return (y_u == 4'd2) || (y_u == 4'd6);
        return (y_u == 4'd0) || (y_u == 4'd4) || (y_u == 4'd8);
    endfunction

    // Last day of the month as {tens, units} BCD
    function automatic logic [5:0] month_end(logic mo_t, logic [3:0] mo_u, logic leap);
        case ({mo_t, mo_u})
            5'h02:                      return leap ? {2'd2, 4'd9} : {2'd2, 4'd8};
            5'h04, 5'h06, 5'h09, 5'h11: return {2'd3, 4'd0};
            default:                    return {2'd3, 4'd1};
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int ASYNC_W = 7,
    parameter int SYNC_W  = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic [ASYNC_W-1:0] async_div,
    input  logic [SYNC_W-1:0]  sync_div,
    output logic [SYNC_W-1:0]  sub_cnt,
    output logic               sec_tick
);

    typedef struct packed {
        logic [ASYNC_W-1:0] a;
        logic [SYNC_W-1:0]  s;
    } pre_t;

    pre_t st_d, st_q;
    logic a_wrap;

    always_comb begin
        st_d     = st_q;
        a_wrap   = !hold && (st_q.a == '0);
        sec_tick = a_wrap && (st_q.s == '0);
        if (hold) begin
            st_d.a = async_div;
            st_d.s = sync_div;
        end else if (a_wrap) begin
            st_d.a = async_div;
            st_d.s = (st_q.s == '0) ? sync_div : st_q.s - 1'b1;
        end else begin
            st_d.a = st_q.a - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sub_cnt = st_q.s;

endmodule

// File: rtl/cal_core.sv
module cal_core
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output clock_t            time_q,
    output cal_date_t         date_q
);

    typedef struct packed {
        clock_t    t;
        cal_date_t d;
    } core_t;

    core_t st_d, st_q;
    logic  min_c, hr_c, day_c, mo_c, yr_c;
    logic [5:0] last_day;

    always_comb begin
        st_d     = st_q;
        min_c    = 1'b0;
        hr_c     = 1'b0;
        day_c    = 1'b0;
        mo_c     = 1'b0;
        yr_c     = 1'b0;
        last_day = month_end(st_q.d.mo_t, st_q.d.mo_u, is_leap(st_q.d.y_t, st_q.d.y_u));
        if (hold) begin
            if (wr_en && !wr_sel) st_d.t = unpack_clock(wr_data);
            if (wr_en && wr_sel)  st_d.d = unpack_date(wr_data);
        end else if (sec_tick) begin
            // seconds
            if (st_q.t.s_u != 4'd9) st_d.t.s_u = st_q.t.s_u + 4'd1;
            else begin
                st_d.t.s_u = 4'd0;
                if (st_q.t.s_t != 3'd5) st_d.t.s_t = st_q.t.s_t + 3'd1;
                else begin
                    st_d.t.s_t = 3'd0;
                    min_c      = 1'b1;
                end
            end
            // minutes
            if (min_c) begin
                if (st_q.t.m_u != 4'd9) st_d.t.m_u = st_q.t.m_u + 4'd1;
                else begin
                    st_d.t.m_u = 4'd0;
                    if (st_q.t.m_t != 3'd5) st_d.t.m_t = st_q.t.m_t + 3'd1;
                    else begin
                        st_d.t.m_t = 3'd0;
                        hr_c       = 1'b1;
                    end
                end
            end
            // hours, 24-hour form
            if (hr_c) begin
                if ({st_q.t.h_t, st_q.t.h_u} == {2'd2, 4'd3}) begin
                    st_d.t.h_t = 2'd0;
                    st_d.t.h_u = 4'd0;
                    day_c      = 1'b1;
                end else if (st_q.t.h_u == 4'd9) begin
                    st_d.t.h_u = 4'd0;
                    st_d.t.h_t = st_q.t.h_t + 2'd1;
                end else begin
                    st_d.t.h_u = st_q.t.h_u + 4'd1;
                end
            end
            // weekday and day of month
            if (day_c) begin
                st_d.d.wd = (st_q.d.wd == 3'd7) ? 3'd1 : st_q.d.wd + 3'd1;
                if ({st_q.d.d_t, st_q.d.d_u} == last_day) begin
                    st_d.d.d_t = 2'd0;
                    st_d.d.d_u = 4'd1;
                    mo_c       = 1'b1;
                end else if (st_q.d.d_u == 4'd9) begin
                    st_d.d.d_u = 4'd0;
                    st_d.d.d_t = st_q.d.d_t + 2'd1;
                end else begin
                    st_d.d.d_u = st_q.d.d_u + 4'd1;
                end
            end
            // month
            if (mo_c) begin
                if ({st_q.d.mo_t, st_q.d.mo_u} == 5'h12) begin
                    st_d.d.mo_t = 1'b0;
                    st_d.d.mo_u = 4'd1;
                    yr_c        = 1'b1;
                end else if (st_q.d.mo_u == 4'd9) begin
                    st_d.d.mo_u = 4'd0;
                    st_d.d.mo_t = 1'b1;
                end else begin
                    st_d.d.mo_u = st_q.d.mo_u + 4'd1;
                end
            end
            // year 00..99
            if (yr_c) begin
                if (st_q.d.y_u != 4'd9) st_d.d.y_u = st_q.d.y_u + 4'd1;
                else begin
                    st_d.d.y_u = 4'd0;
                    st_d.d.y_t = (st_q.d.y_t == 4'd9) ? 4'd0 : st_q.d.y_t + 4'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.t <= CLOCK_RST;
            st_q.d <= DATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign time_q = st_q.t;
    assign date_q = st_q.d;

endmodule

// File: rtl/cal_shadow.sv
module cal_shadow
    import cal_pkg::*;
#(
    parameter int SYNC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYNC_W-1:0] sub_live,
    input  clock_t            time_live,
    input  cal_date_t         date_live,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    input  logic              sync_clr,
    output logic [SYNC_W-1:0] sub_sh,
    output clock_t            time_sh,
    output cal_date_t         date_sh,
    output logic              sync_flag
);

    typedef struct packed {
        logic [SYNC_W-1:0] sub;
        clock_t            t;
        cal_date_t         d;
        logic              lock_t;
        logic              lock_d;
        logic              flag;
    } shadow_t;

    shadow_t st_d, st_q;
    logic    rd_sub, rd_time, rd_date, freeze_t, freeze_d;

    always_comb begin
        rd_sub   = rd_en && (rd_sel_e'(rd_sel) == SEL_SUB);
        rd_time  = rd_en && (rd_sel_e'(rd_sel) == SEL_TIME);
        rd_date  = rd_en && (rd_sel_e'(rd_sel) == SEL_DATE);
        freeze_t = st_q.lock_t || rd_sub;
        freeze_d = st_q.lock_d || rd_sub || rd_time;
        st_d     = st_q;
        if (!freeze_t) begin
            st_d.sub = sub_live;
            st_d.t   = time_live;
        end
        if (!freeze_d) st_d.d = date_live;
        st_d.lock_t = !rd_date && freeze_t;
        st_d.lock_d = !rd_date && freeze_d;
        if (sync_clr)       st_d.flag = 1'b0;
        else if (!freeze_d) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            st_q.t <= CLOCK_RST;
            st_q.d <= DATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign sub_sh    = st_q.sub;
    assign time_sh   = st_q.t;
    assign date_sh   = st_q.d;
    assign sync_flag = st_q.flag;

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int ASYNC_W = 7,
    parameter int SYNC_W  = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_mode,
    input  logic [ASYNC_W-1:0] async_div,
    input  logic [SYNC_W-1:0]  sync_div,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [1:0]         rd_sel,
    output logic [WORD_W-1:0]  rd_data,
    input  logic               sync_clr,
    output logic               sync_flag
);

    logic [SYNC_W-1:0] sub_live, sub_sh;
    logic              sec_tick;
    clock_t            time_live, time_sh;
    cal_date_t         date_live, date_sh;

    cal_prescaler #(.ASYNC_W(ASYNC_W), .SYNC_W(SYNC_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (init_mode),
        .async_div(async_div),
        .sync_div (sync_div),
        .sub_cnt  (sub_live),
        .sec_tick (sec_tick)
    );

    cal_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (init_mode),
        .sec_tick(sec_tick),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .time_q  (time_live),
        .date_q  (date_live)
    );

    cal_shadow #(.SYNC_W(SYNC_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .sub_live (sub_live),
        .time_live(time_live),
        .date_live(date_live),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel),
        .sync_clr (sync_clr),
        .sub_sh   (sub_sh),
        .time_sh  (time_sh),
        .date_sh  (date_sh),
        .sync_flag(sync_flag)
    );

    always_comb begin
        rd_data = '0;
        case (rd_sel_e'(rd_sel))
            SEL_SUB:  rd_data[SYNC_W-1:0] = sub_sh;
            SEL_TIME: rd_data = pack_clock(time_sh);
            SEL_DATE: rd_data = pack_date(date_sh);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cal_checker.sv
module cal_checker
    import cal_pkg::*;
#(
    parameter int SYNC_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_mode,
    input logic [SYNC_W-1:0] sync_div,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        rd_sel,
    input logic              sync_clr,
    input logic              sync_flag,
    input logic              sec_tick,
    input logic [SYNC_W-1:0] sub_live,
    input clock_t            time_live,
    input cal_date_t         date_live,
    input cal_date_t         date_sh
);

    AST_TICK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> (sub_live == '0)); // R1

    AST_SUB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !init_mode |-> (sub_live <= sync_div)); // R2

    AST_TIME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (time_live.s_t <= 3'd5) && (time_live.m_t <= 3'd5)
        && ({time_live.h_t, time_live.h_u} <= {2'd2, 4'd3})); // R3

    AST_WEEKDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (date_live.wd != 3'd0)); // R5

    AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (init_mode && !wr_en) |=> ($stable(time_live) && $stable(date_live))); // R6

    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_mode && wr_en && !sec_tick) |=> ($stable(time_live) && $stable(date_live))); // R6

    AST_DATE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'd1) |=> $stable(date_sh)); // R7

    AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> !sync_flag); // R8

endmodule

bind bcd_calendar cal_checker #(.SYNC_W(SYNC_W)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_mode(init_mode),
    .sync_div (sync_div),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .sync_clr (sync_clr),
    .sync_flag(sync_flag),
    .sec_tick (sec_tick),
    .sub_live (sub_live),
    .time_live(time_live),
    .date_live(date_live),
    .date_sh  (date_sh)
);

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_mode = 1'b1;
    logic [6:0]  async_div = 7'd1;
    logic [14:0] sync_div = 15'd2;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'd1;
    logic [31:0] rd_data;
    logic        sync_clr = 1'b0;
    logic        sync_flag;

    int checks = 0;
    int errors = 0;
    int period;
    int mh, mm, ms, my, mmo, md, mw;

    always #10 clk = ~clk;

    bcd_calendar u_bcd_calendar (
        .clk(clk), .rst_n(rst_n), .init_mode(init_mode),
        .async_div(async_div), .sync_div(sync_div),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .sync_clr(sync_clr), .sync_flag(sync_flag)
    );

    function automatic logic [31:0] tword(int h, int m, int s);
        logic [31:0] w = '0;
        w[3:0]   = 4'(s % 10);
        w[6:4]   = 3'(s / 10);
        w[11:8]  = 4'(m % 10);
        w[14:12] = 3'(m / 10);
        w[19:16] = 4'(h % 10);
        w[21:20] = 2'(h / 10);
        return w;
    endfunction

    function automatic logic [31:0] dword(int y, int mo, int d, int wd);
        logic [31:0] w = '0;
        w[3:0]   = 4'(d % 10);
        w[5:4]   = 2'(d / 10);
        w[11:8]  = 4'(mo % 10);
        w[12]    = 1'(mo / 10);
        w[19:16] = 4'(y % 10);
        w[23:20] = 4'(y / 10);
        w[26:24] = 3'(wd);
        return w;
    endfunction

    function automatic int days_in(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_second();
        ms++;
        if (ms == 60) begin ms = 0; mm++; end
        if (mm == 60) begin mm = 0; mh++; end
        if (mh == 24) begin
            mh = 0;
            mw = (mw == 7) ? 1 : mw + 1;
            md++;
            if (md > days_in(mmo, my)) begin md = 1; mmo++; end
            if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
        end
    endtask

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(logic [1:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    // Load model and design in init mode; returns with init low at a negedge
    task automatic load(int h, int m, int s, int y, int mo, int d, int wd);
        mh = h; mm = m; ms = s; my = y; mmo = mo; md = d; mw = wd;
        init_mode = 1'b1;
        edges(2);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = tword(h, m, s);
        edges(1);
        wr_sel = 1'b1; wr_data = dword(y, mo, d, wd);
        edges(1);
        wr_en = 1'b0;
        edges(1);
        init_mode = 1'b0;
    endtask

    task automatic run_case(int h, int m, int s, int y, int mo, int d, int wd, int k, string req);
        logic [31:0] v;
        load(h, m, s, y, mo, d, wd);
        edges(k * period + 3);
        repeat (k) model_second();
        peek(2'd1, v);
        check(v == tword(mh, mm, ms), req, v, tword(mh, mm, ms));
        peek(2'd2, v);
        check(v == dword(my, mmo, md, mw), req, v, dword(my, mmo, md, mw));
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));

        // R9: reset state
        edges(2);
        peek(2'd1, v); check(v == 32'h0, "R9 time", v, 32'h0);
        peek(2'd2, v); check(v == dword(0, 1, 1, 1), "R9 date", v, dword(0, 1, 1, 1));
        check(sync_flag == 1'b0, "R9 flag", {31'd0, sync_flag}, 32'd0);
        rst_n = 1'b1;
        edges(2);
        check(sync_flag == 1'b1, "R8 flag after copy", {31'd0, sync_flag}, 32'd1);

        // R1 and R2: exact tick timing and sub-second countdown, A=3 S=4
        async_div = 7'd3; sync_div = 15'd4; period = 20;
        load(10, 20, 30, 40, 6, 15, 3);
        for (int e = 1; e <= 2 * period; e++) begin
            int exp_ss;
            edges(1);
            exp_ss = 4 - (((e - 1) / 4) % 5);
            peek(2'd0, v);
            check(v == 32'(exp_ss), "R2 subsecond", v, 32'(exp_ss));
            if (e == period) begin
                peek(2'd1, v);
                check(v == tword(10, 20, 30), "R1 before tick", v, tword(10, 20, 30));
            end
            if (e == period + 1) begin
                peek(2'd1, v);
                check(v == tword(10, 20, 31), "R1 after tick", v, tword(10, 20, 31));
            end
        end

        // R6: init freezes counting; prescalers reload
        init_mode = 1'b1;
        edges(25);
        peek(2'd1, v); check(v == tword(10, 20, 32), "R6 hold time", v, tword(10, 20, 32));
        peek(2'd0, v); check(v == 32'd4, "R6 hold subsecond", v, 32'd4);

        // R6: write outside init is ignored
        async_div = 7'd1; sync_div = 15'd2; period = 6;
        load(1, 2, 3, 5, 5, 5, 5);
        edges(3);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = tword(12, 34, 56);
        edges(1);
        wr_sel = 1'b1; wr_data = dword(77, 7, 7, 7);
        edges(1);
        wr_en = 1'b0;
        edges(period - 2);
        peek(2'd1, v); check(v == tword(1, 2, 4), "R6 ignored write time", v, tword(1, 2, 4));
        peek(2'd2, v); check(v == dword(5, 5, 5, 5), "R6 ignored write date", v, dword(5, 5, 5, 5));

        // Directed rollovers
        run_case(12, 34, 59, 50, 3, 10, 2, 1, "R3 minute carry");
        run_case(9, 59, 59, 50, 3, 10, 2, 1, "R3 hour carry");
        run_case(23, 59, 59, 10, 4, 30, 4, 1, "R4 30-day month");
        run_case(23, 59, 59, 10, 1, 31, 4, 1, "R4 31-day month");
        run_case(23, 59, 59, 23, 2, 28, 1, 1, "R4 non-leap February");
        run_case(23, 59, 59, 24, 2, 28, 1, 1, "R4 leap February 28");
        run_case(23, 59, 59, 24, 2, 29, 6, 2, "R4 leap February 29");
        run_case(23, 59, 59, 0, 2, 28, 2, 1, "R4 year 00 leap");
        run_case(23, 59, 59, 99, 12, 31, 3, 1, "R4 year wrap");
        run_case(23, 59, 58, 45, 9, 9, 7, 2, "R5 weekday wrap");

        // Random valid loads biased toward carries
        for (int i = 0; i < 24; i++) begin
            int h, m, s, y, mo, d, wd, k;
            y  = $urandom_range(99, 0);
            mo = $urandom_range(12, 1);
            d  = ($urandom_range(1, 0) == 1) ? days_in(mo, y) : $urandom_range(days_in(mo, y), 1);
            wd = $urandom_range(7, 1);
            h  = ($urandom_range(1, 0) == 1) ? 23 : $urandom_range(23, 0);
            m  = ($urandom_range(1, 0) == 1) ? 59 : $urandom_range(59, 0);
            s  = $urandom_range(59, 55);
            k  = $urandom_range(3, 1);
            run_case(h, m, s, y, mo, d, wd, k, "R4 R3 random");
        end

        // R7 and R8: locked read across a day change
        load(23, 59, 59, 10, 4, 30, 2);
        edges(2);
        rd_en = 1'b1; rd_sel = 2'd1; #1; v = rd_data;
        check(v == tword(23, 59, 59), "R7 locked time read", v, tword(23, 59, 59));
        edges(1);
        rd_en = 1'b0;
        edges(1);
        sync_clr = 1'b1;
        edges(1);
        sync_clr = 1'b0;
        edges(period);
        peek(2'd2, v); check(v == dword(10, 4, 30, 2), "R7 date frozen", v, dword(10, 4, 30, 2));
        peek(2'd1, v); check(v == tword(0, 0, 0), "R7 time still live", v, tword(0, 0, 0));
        check(sync_flag == 1'b0, "R8 flag held clear", {31'd0, sync_flag}, 32'd0);
        rd_en = 1'b1; rd_sel = 2'd2; #1; v = rd_data;
        check(v == dword(10, 4, 30, 2), "R7 date read coherent", v, dword(10, 4, 30, 2));
        edges(1);
        rd_en = 1'b0;
        edges(1);
        peek(2'd2, v); check(v == dword(10, 5, 1, 3), "R7 date released", v, dword(10, 5, 1, 3));
        check(sync_flag == 1'b1, "R8 flag set again", {31'd0, sync_flag}, 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule